// File: doc/BRIEF.md
# PCI-to-ISA Posted Write Buffer

This block sits on the target side of a bridge between a PCI bus and an ISA bus. It claims the PCI cycles that an external decoder marks as aimed at the ISA side and turns each one into a single request toward an ISA cycle engine. Memory writes can be posted: the block keeps one 32-bit word and its byte enables, completes the PCI data phase at once, and lets the slower ISA cycle run later. Every other cycle waits for the ISA side to finish before the PCI data phase completes.

Posting is off after reset and is turned on by a control-register bit that arrives on a single input. Only one word is ever held. A second write that finds the word still in place gets wait states, and a read waits until the word has drained so that it cannot overtake it. The block does not take bursts. If a master keeps `pci_frame` high through the first data phase, the block completes that phase and then ends the transaction with a target abort.

The PCI side is simplified. Address, command, data and byte enables are valid while `pci_irdy` is high. A data phase completes on the clock edge where `pci_irdy` and `pci_trdy` are both high. The ISA side completes a request with a single-cycle `isa_ack`.

Top module: `pci_isa_post_wbuf`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pci_trdy`, `pci_stop`, `pci_tabort` and `isa_req` are low.
- R2: Posting is governed by `ctl_post_en` alone. The same memory write is posted when the input is 1 and is not posted when it is 0.
- R3: A posted memory write that finds the buffer empty completes at once. It is sampled at edge k. `pci_trdy` is high in the cycle after edge k. In that same cycle `isa_req` is high with `isa_wr`=1, `isa_mem`=1 and the write's address, data and byte enables.
- R4: A memory write with posting off holds `pci_trdy` low until the ISA side acknowledges it. `pci_trdy` rises in the cycle after the edge that carries `isa_ack`.
- R5: Only command 4'b0111 (memory write) is posted. An I/O write (4'b0011) waits for `isa_ack` even with posting on, and its request shows `isa_mem`=0.
- R6: A posted write that arrives while the buffer is full gets wait states (`pci_trdy` low). It is loaded on the same edge as the `isa_ack` that drains the old word. From the cycle after that edge, `isa_req` stays high with the new contents and `pci_trdy` is high.
- R7: A read (4'b0110 memory, 4'b0010 I/O) is not forwarded while a posted word is pending. Once the word drains, a request with `isa_wr`=0 is raised. `pci_trdy` rises in the cycle after its `isa_ack`, and `pci_rdata` then equals `isa_rdata` as sampled with that ack.
- R8: If `pci_frame` is still high on the edge where the first data phase completes, then from the next cycle `pci_stop` and `pci_tabort` are high and `pci_trdy` is low. No second phase is accepted, and only the first word reaches the ISA side. `pci_stop` and `pci_tabort` are released in the cycle after the edge that sees both `pci_frame` and `pci_irdy` low.
- R9: A cycle with `pci_hit` low is ignored. It raises neither `pci_trdy` nor `isa_req`.
- R10: Once raised, `isa_req` stays high, and its address, data and byte enables stay stable, until an edge that carries `isa_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_post_en | input | 1 | Posting enable from the bridge control register |
| pci_frame | input | 1 | High during a data phase when the master wants more phases |
| pci_irdy | input | 1 | Master ready; command, address, data and byte enables are valid |
| pci_hit | input | 1 | The address decodes to the ISA side |
| pci_cmd | input | 4 | Bus command |
| pci_addr | input | AW | Address |
| pci_wdata | input | DW | Write data |
| pci_be | input | DW/8 | Byte enables, active high |
| pci_trdy | output | 1 | Target ready; the data phase completes when it is high with `pci_irdy` |
| pci_stop | output | 1 | Target requests the end of the transaction |
| pci_tabort | output | 1 | The stop is a target abort |
| pci_rdata | output | DW | Read data |
| isa_req | output | 1 | An ISA cycle is pending |
| isa_wr | output | 1 | Pending cycle is a write |
| isa_mem | output | 1 | Pending cycle is in memory space (else I/O) |
| isa_addr | output | AW | Pending address |
| isa_data | output | DW | Pending write data |
| isa_be | output | DW/8 | Pending byte enables |
| isa_ack | input | 1 | ISA engine finished the pending cycle (one-cycle pulse) |
| isa_rdata | input | DW | Read data returned with `isa_ack` |

## Verification
Two things can happen on the same edge: the ISA acknowledge that empties the buffer, and the load of a write that has been waiting for it. The bench fills the buffer with a posted write and presents a second write at once. It holds the acknowledge back for a few cycles and then pulses it. The result is judged by three things: `isa_req` never drops, its contents switch from the first word to the second on exactly that edge, and `pci_trdy` for the waiting write rises one cycle later. A read queued behind a posted word goes through the same drain-and-load edge. There the bench also checks that the request turns into a read only after the ack.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITQ,
    ST_HOLD,
    ST_DATA,
    ST_ABORT
  } tgt_state_e;

endpackage

// File: rtl/pwb_cmd_dec.sv
module pwb_cmd_dec (
  input  logic [3:0] cmd,
  input  logic       post_en,
  output logic       cmd_wr,
  output logic       cmd_mem,
  output logic       post_ok
);
  import pwb_pkg::*;

  always_comb begin
    cmd_wr  = (cmd == CMD_MEM_WR) || (cmd == CMD_IO_WR);
    cmd_mem = (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_RD);
    post_ok = post_en && (cmd == CMD_MEM_WR);
  end

endmodule

// File: rtl/pwb_entry.sv
module pwb_entry #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           drain,
  input  logic           ld_wr,
  input  logic           ld_mem,
  input  logic [AW-1:0]  ld_addr,
  input  logic [DW-1:0]  ld_data,
  input  logic [BEW-1:0] ld_be,
  output logic           full,
  output logic           q_wr,
  output logic           q_mem,
  output logic [AW-1:0]  q_addr,
  output logic [DW-1:0]  q_data,
  output logic [BEW-1:0] q_be
);

  // Single slot; a load on the draining edge replaces the old word.
  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      q_wr   <= 1'b0;
      q_mem  <= 1'b0;
      q_addr <= '0;
      q_data <= '0;
      q_be   <= '0;
    end else if (load) begin
      full   <= 1'b1;
      q_wr   <= ld_wr;
      q_mem  <= ld_mem;
      q_addr <= ld_addr;
      q_data <= ld_data;
      q_be   <= ld_be;
    end else if (drain) begin
      full   <= 1'b0;
    end
  end

endmodule

// File: rtl/pwb_tgt_ctl.sv
module pwb_tgt_ctl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame,
  input  logic          irdy,
  input  logic          hit,
  input  logic          post_ok,
  input  logic          ent_full,
  input  logic          ent_wr,
  input  logic          isa_ack,
  input  logic [DW-1:0] isa_rdata,
  output logic          ent_load,
  output logic          trdy,
  output logic          stop,
  output logic          tabort,
  output logic [DW-1:0] rdata
);
  import pwb_pkg::*;

  tgt_state_e st, st_n;
  logic       room;
  logic       rd_cap;

  assign room = !ent_full || isa_ack;

  always_comb begin
    st_n     = st;
    ent_load = 1'b0;
    rd_cap   = 1'b0;
    case (st)
      ST_IDLE, ST_WAITQ: begin
        if (irdy && hit) begin
          if (room) begin
            ent_load = 1'b1;
            st_n     = post_ok ? ST_DATA : ST_HOLD;
          end else begin
            st_n = ST_WAITQ;
          end
        end else begin
          st_n = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (isa_ack) begin
          st_n   = ST_DATA;
          rd_cap = !ent_wr;
        end
      end
      ST_DATA:  st_n = frame ? ST_ABORT : ST_IDLE;
      ST_ABORT: if (!frame && !irdy) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      trdy   <= 1'b0;
      stop   <= 1'b0;
      tabort <= 1'b0;
      rdata  <= '0;
    end else begin
      st     <= st_n;
      trdy   <= (st_n == ST_DATA);
      stop   <= (st_n == ST_ABORT);
      tabort <= (st_n == ST_ABORT);
      if (rd_cap) rdata <= isa_rdata;
    end
  end

endmodule

// File: rtl/pci_isa_post_wbuf.sv
module pci_isa_post_wbuf #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ctl_post_en,
  input  logic           pci_frame,
  input  logic           pci_irdy,
  input  logic           pci_hit,
  input  logic [3:0]     pci_cmd,
  input  logic [AW-1:0]  pci_addr,
  input  logic [DW-1:0]  pci_wdata,
  input  logic [BEW-1:0] pci_be,
  output logic           pci_trdy,
  output logic           pci_stop,
  output logic           pci_tabort,
  output logic [DW-1:0]  pci_rdata,
  output logic           isa_req,
  output logic           isa_wr,
  output logic           isa_mem,
  output logic [AW-1:0]  isa_addr,
  output logic [DW-1:0]  isa_data,
  output logic [BEW-1:0] isa_be,
  input  logic           isa_ack,
  input  logic [DW-1:0]  isa_rdata
);

  logic cmd_wr, cmd_mem, post_ok;
  logic ent_load;

  pwb_cmd_dec u_dec (
    .cmd     (pci_cmd),
    .post_en (ctl_post_en),
    .cmd_wr  (cmd_wr),
    .cmd_mem (cmd_mem),
    .post_ok (post_ok)
  );

  pwb_entry #(.AW(AW), .DW(DW)) u_entry (
    .clk     (clk),
    .rst     (rst),
    .load    (ent_load),
    .drain   (isa_ack),
    .ld_wr   (cmd_wr),
    .ld_mem  (cmd_mem),
    .ld_addr (pci_addr),
    .ld_data (pci_wdata),
    .ld_be   (pci_be),
    .full    (isa_req),
    .q_wr    (isa_wr),
    .q_mem   (isa_mem),
    .q_addr  (isa_addr),
    .q_data  (isa_data),
    .q_be    (isa_be)
  );

  pwb_tgt_ctl #(.DW(DW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .frame     (pci_frame),
    .irdy      (pci_irdy),
    .hit       (pci_hit),
    .post_ok   (post_ok),
    .ent_full  (isa_req),
    .ent_wr    (isa_wr),
    .isa_ack   (isa_ack),
    .isa_rdata (isa_rdata),
    .ent_load  (ent_load),
    .trdy      (pci_trdy),
    .stop      (pci_stop),
    .tabort    (pci_tabort),
    .rdata     (pci_rdata)
  );

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BEW = DW / 8
) (
  input logic           clk,
  input logic           rst,
  input logic           ctl_post_en,
  input logic           pci_frame,
  input logic           pci_irdy,
  input logic           pci_hit,
  input logic [3:0]     pci_cmd,
  input logic           pci_trdy,
  input logic           pci_stop,
  input logic           pci_tabort,
  input logic           isa_req,
  input logic           isa_ack,
  input logic [AW-1:0]  isa_addr,
  input logic [DW-1:0]  isa_data,
  input logic [BEW-1:0] isa_be
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!pci_trdy && !pci_stop && !pci_tabort && !isa_req)); // R1

  AST_NONPOST_WAITS_ACK: assert property (@(posedge clk) disable iff (rst)
    ($rose(pci_trdy) && !(ctl_post_en && pci_cmd == pwb_pkg::CMD_MEM_WR)) |-> $past(isa_ack)); // R4

  AST_BURST_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (pci_trdy && pci_irdy && pci_frame) |=> (pci_stop && pci_tabort && !pci_trdy)); // R8

  AST_NO_READY_DURING_STOP: assert property (@(posedge clk) disable iff (rst)
    !(pci_trdy && pci_stop)); // R8

  AST_REQ_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(isa_req) |-> $past(pci_hit && pci_irdy)); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (isa_req && !isa_ack) |=> isa_req); // R10

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (isa_req && !isa_ack) |=> ($stable(isa_addr) && $stable(isa_data) && $stable(isa_be))); // R10

endmodule

bind pci_isa_post_wbuf pwb_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/pci_isa_post_wbuf_bench.sv
module pci_isa_post_wbuf_bench;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int BEW = DW / 8;
  localparam logic [3:0] C_IO_RD  = 4'b0010;
  localparam logic [3:0] C_IO_WR  = 4'b0011;
  localparam logic [3:0] C_MEM_RD = 4'b0110;
  localparam logic [3:0] C_MEM_WR = 4'b0111;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic           ctl_post_en = 1'b0;
  logic           pci_frame = 1'b0, pci_irdy = 1'b0, pci_hit = 1'b0;
  logic [3:0]     pci_cmd = '0;
  logic [AW-1:0]  pci_addr = '0;
  logic [DW-1:0]  pci_wdata = '0;
  logic [BEW-1:0] pci_be = '0;
  logic           pci_trdy, pci_stop, pci_tabort;
  logic [DW-1:0]  pci_rdata;
  logic           isa_req, isa_wr, isa_mem;
  logic [AW-1:0]  isa_addr;
  logic [DW-1:0]  isa_data;
  logic [BEW-1:0] isa_be;
  logic           isa_ack = 1'b0;
  logic [DW-1:0]  isa_rdata = '0;

  pci_isa_post_wbuf #(.AW(AW), .DW(DW)) u_pci_isa_post_wbuf (.*);

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] cmd, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [BEW-1:0] be, input logic frm);
    pci_cmd = cmd; pci_addr = a; pci_wdata = d; pci_be = be;
    pci_frame = frm; pci_irdy = 1'b1; pci_hit = 1'b1;
  endtask

  task automatic bus_idle;
    pci_frame = 1'b0; pci_irdy = 1'b0; pci_hit = 1'b0;
  endtask

  task automatic ack_pulse(input logic [DW-1:0] rd);
    isa_ack = 1'b1; isa_rdata = rd;
    nclk(1);
    isa_ack = 1'b0;
  endtask

  task automatic t_reset;
    nclk(3);
    chk("R1 trdy in reset", pci_trdy, 0);
    chk("R1 req in reset", isa_req, 0);
    rst = 1'b0;
    nclk(1);
    chk("R1 trdy", pci_trdy, 0);
    chk("R1 stop", pci_stop, 0);
    chk("R1 tabort", pci_tabort, 0);
    chk("R1 isa_req", isa_req, 0);
  endtask

  task automatic t_posted;
    ctl_post_en = 1'b1;
    drive(C_MEM_WR, 32'h000C_8010, 32'h1234_5678, 4'b0101, 1'b0);
    nclk(1);
    chk("R3 trdy at once", pci_trdy, 1);
    chk("R3 req", isa_req, 1);
    chk("R3 wr", isa_wr, 1);
    chk("R3 mem", isa_mem, 1);
    chk("R3 addr", isa_addr, 32'h000C_8010);
    chk("R3 data", isa_data, 32'h1234_5678);
    chk("R3 be", isa_be, 4'b0101);
    nclk(1);
    chk("R3 trdy single", pci_trdy, 0);
    bus_idle();
    ack_pulse('0);
    chk("R3 drained", isa_req, 0);
  endtask

  task automatic t_disabled;
    ctl_post_en = 1'b0;
    drive(C_MEM_WR, 32'h000D_0000, 32'hA5A5_0F0F, 4'b0011, 1'b0);
    nclk(1);
    chk("R4 no trdy", pci_trdy, 0);
    chk("R4 req", isa_req, 1);
    nclk(2);
    chk("R4 still waiting", pci_trdy, 0);
    ack_pulse('0);
    chk("R4 trdy after ack", pci_trdy, 1);
    chk("R4 req cleared", isa_req, 0);
    nclk(1);
    chk("R4 trdy drops", pci_trdy, 0);
    bus_idle();
    nclk(1);
    ctl_post_en = 1'b1;
    drive(C_MEM_WR, 32'h000D_0004, 32'h0BAD_CAFE, 4'b1111, 1'b0);
    nclk(1);
    chk("R2 enable posts", pci_trdy, 1);
    nclk(1);
    bus_idle();
    ack_pulse('0);
  endtask

  task automatic t_io_write;
    ctl_post_en = 1'b1;
    drive(C_IO_WR, 32'h0000_0378, 32'h0000_00AB, 4'b0001, 1'b0);
    nclk(1);
    chk("R5 io not posted", pci_trdy, 0);
    chk("R5 io mem flag", isa_mem, 0);
    chk("R5 io wr flag", isa_wr, 1);
    nclk(1);
    chk("R5 io waits", pci_trdy, 0);
    ack_pulse('0);
    chk("R5 trdy after ack", pci_trdy, 1);
    nclk(1);
    bus_idle();
  endtask

  task automatic t_back2back;
    ctl_post_en = 1'b1;
    drive(C_MEM_WR, 32'h000E_0000, 32'h1111_1111, 4'b1111, 1'b0);
    nclk(1);
    chk("R6 first posted", pci_trdy, 1);
    nclk(1);
    drive(C_MEM_WR, 32'h000E_0100, 32'h2222_2222, 4'b1100, 1'b0);
    nclk(1);
    chk("R6 second waits", pci_trdy, 0);
    chk("R10 addr held", isa_addr, 32'h000E_0000);
    nclk(1);
    chk("R6 still waits", pci_trdy, 0);
    chk("R10 data held", isa_data, 32'h1111_1111);
    ack_pulse('0);
    chk("R6 trdy after drain", pci_trdy, 1);
    chk("R6 req kept", isa_req, 1);
    chk("R6 new addr", isa_addr, 32'h000E_0100);
    chk("R6 new data", isa_data, 32'h2222_2222);
    chk("R6 new be", isa_be, 4'b1100);
    nclk(1);
    chk("R6 trdy drops", pci_trdy, 0);
    bus_idle();
    ack_pulse('0);
    chk("R6 empty", isa_req, 0);
  endtask

  task automatic t_read;
    ctl_post_en = 1'b1;
    drive(C_MEM_WR, 32'h000F_0000, 32'h3333_3333, 4'b1111, 1'b0);
    nclk(1);
    chk("R7 write posted", pci_trdy, 1);
    nclk(1);
    drive(C_MEM_RD, 32'h000F_0040, 32'h0, 4'b1111, 1'b0);
    nclk(1);
    chk("R7 read waits", pci_trdy, 0);
    chk("R7 write still pending", isa_wr, 1);
    ack_pulse('0);
    chk("R7 read issued", isa_req, 1);
    chk("R7 read flag", isa_wr, 0);
    chk("R7 read addr", isa_addr, 32'h000F_0040);
    chk("R7 no trdy yet", pci_trdy, 0);
    nclk(1);
    chk("R7 still waiting", pci_trdy, 0);
    ack_pulse(32'hCAFE_F00D);
    chk("R7 trdy after ack", pci_trdy, 1);
    chk("R7 rdata", pci_rdata, 32'hCAFE_F00D);
    chk("R7 req cleared", isa_req, 0);
    nclk(1);
    bus_idle();
    drive(C_IO_RD, 32'h0000_0060, 32'h0, 4'b0001, 1'b0);
    nclk(1);
    chk("R7 io read mem flag", isa_mem, 0);
    ack_pulse(32'h0000_005A);
    chk("R7 io rdata", pci_rdata, 32'h0000_005A);
    nclk(1);
    bus_idle();
  endtask

  task automatic t_burst;
    ctl_post_en = 1'b1;
    drive(C_MEM_WR, 32'h000A_0000, 32'h4444_4444, 4'b1111, 1'b1);
    nclk(1);
    chk("R8 first phase", pci_trdy, 1);
    chk("R8 no early stop", pci_stop, 0);
    nclk(1);
    pci_wdata = 32'h5555_5555;
    pci_addr  = 32'h000A_0004;
    chk("R8 stop", pci_stop, 1);
    chk("R8 tabort", pci_tabort, 1);
    chk("R8 no second trdy", pci_trdy, 0);
    nclk(2);
    chk("R8 stop held", pci_stop, 1);
    chk("R8 still no trdy", pci_trdy, 0);
    chk("R8 first data only", isa_data, 32'h4444_4444);
    bus_idle();
    nclk(1);
    chk("R8 stop released", pci_stop, 0);
    chk("R8 tabort released", pci_tabort, 0);
    ack_pulse('0);
    chk("R8 one request", isa_req, 0);
    nclk(1);
    chk("R8 no extra request", isa_req, 0);
  endtask

  task automatic t_nohit;
    ctl_post_en = 1'b1;
    drive(C_MEM_WR, 32'h0100_0000, 32'h6666_6666, 4'b1111, 1'b0);
    pci_hit = 1'b0;
    nclk(3);
    chk("R9 no trdy", pci_trdy, 0);
    chk("R9 no req", isa_req, 0);
    bus_idle();
    nclk(1);
  endtask

  initial begin
    t_reset();
    t_posted();
    t_disabled();
    t_io_write();
    t_back2back();
    t_read();
    t_burst();
    t_nohit();
    nclk(2);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule